// File: doc/BRIEF.md
# I/O Page Table Walk Step Checker

This block validates a single step of a multi-level I/O page table walk. For each request it receives the translation fields of the device table entry, the page table entry just fetched for the current level, the requested access and the I/O virtual address. One cycle later it reports one of three outcomes: descend to the next level, finish the translation, or raise an I/O page fault with a fault record.

The walk sequencer outside this block fetches the entries and assembles the final physical address. It presents one step per request and acts on the reported outcome. The checks always run in one fixed order, and only the first check that fails is reported. Each level indexes 9 address bits above a 12-bit page offset. A next-level code of zero marks a leaf.

Top module: `pw_walk_check`

## Requirements
- R1: While rst_ni is low, and until the first request after reset, rsp_valid_o, action_o, cause_o, next_lvl_o and both fault flags read 0.
- R2: A request sampled at a rising edge with req_i high produces rsp_valid_o high after that edge, for exactly one cycle. flt_dev_id_o, flt_dom_id_o, flt_va_o and flt_op_o then carry that request's dev_id_i, dte_dom_id_i, va_i and op_i.
- R3: If dte_valid_i is 0, the step faults (action_o = 2) with cause_o = 1, flt_present_o = 0 and flt_perm_o = 0. Translation is never bypassed.
- R4: A root level dte_root_lvl_i outside 1..6 faults with cause_o = 2 and flt_present_o = 1.
- R5: If any set bit of acc_i (bit 0 read, bit 1 write) is missing from pte_perm_i, the step faults with cause_o = 3, flt_present_o = 1 and flt_perm_o = 1.
- R6: If pte_present_i is 0, the step faults with cause_o = 4 and flt_present_o = 0.
- R7: A next-level code above 6 faults with cause_o = 5 and flt_present_o = 1.
- R8: A nonzero next level that is not strictly below cur_lvl_i faults with cause_o = 6 and flt_present_o = 1.
- R9: At a leaf (next level 0), a page size code pte_pgsz_i that is not below cur_lvl_i faults with cause_o = 7 and flt_present_o = 1.
- R10: When the next level n is nonzero and lies more than one below the current level c, va_i bits [12+9n, 12+9(c-1)) must all be 0. Otherwise the step faults with cause_o = 8 and flt_present_o = 1.
- R11: The checks are evaluated in the order R3, R4, R5, R6, R7, R8, R9, R10. Only the first failing one sets cause_o. On a response that is not a fault, cause_o and both fault flags are 0.
- R12: A step with no failing check reports action_o = 0 (descend) with next_lvl_o equal to the next level if that level is nonzero. Otherwise it reports action_o = 1 (done) with next_lvl_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Step request strobe |
| dev_id_i | input | 16 | Requesting device identifier |
| dte_valid_i | input | 1 | Translation-valid bit of the device table entry |
| dte_root_lvl_i | input | 3 | Root page table level |
| dte_dom_id_i | input | 16 | Domain identifier |
| cur_lvl_i | input | 3 | Level of the entry under check |
| pte_present_i | input | 1 | Entry present bit |
| pte_perm_i | input | 2 | Entry permissions, bit 0 read, bit 1 write |
| pte_next_lvl_i | input | 3 | Next-level code, 0 = leaf |
| pte_pgsz_i | input | 3 | Leaf page size code |
| acc_i | input | 2 | Requested access, bit 0 read, bit 1 write |
| op_i | input | 2 | Operation type, passed into the record |
| va_i | input | 64 | I/O virtual address |
| rsp_valid_o | output | 1 | Response strobe |
| action_o | output | 2 | 0 descend, 1 done, 2 fault |
| next_lvl_o | output | 3 | Level to descend to |
| cause_o | output | 4 | First failing check, 0 none |
| flt_present_o | output | 1 | Fault record present flag |
| flt_perm_o | output | 1 | Fault record permission-denied flag |
| flt_dev_id_o | output | 16 | Record device identifier |
| flt_dom_id_o | output | 16 | Record domain identifier |
| flt_va_o | output | 64 | Record virtual address |
| flt_op_o | output | 2 | Record operation type |

## Verification
The permission check and the present check can both fail on the same step. This happens whenever a non-present entry also lacks the requested access bit. The bench drives that combination and expects the permission cause with the present flag set. It drives further steps where several checks fail at once, such as an invalid table entry together with an absent entry and a bad next-level code, or an absent entry together with a bad next-level code. In each of those cases it expects only the earliest cause in the priority order. The boundary bits of the skipped-level range are exercised on both sides.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int VA_W     = 64;
  localparam int LVL_W    = 3;
  localparam int MAX_LVL  = 6;
  localparam int PG_SHIFT = 12;
  localparam int IDX_W    = 9;
  localparam int ID_W     = 16;
  localparam int OP_W     = 2;
  localparam int ACC_W    = 2;

  typedef enum logic [1:0] {
    ACT_DESCEND = 2'd0,
    ACT_DONE    = 2'd1,
    ACT_FAULT   = 2'd2
  } action_e;

  typedef enum logic [3:0] {
    C_NONE    = 4'd0,
    C_XLATE   = 4'd1,
    C_ROOT    = 4'd2,
    C_PERM    = 4'd3,
    C_NOTPRES = 4'd4,
    C_NXT     = 4'd5,
    C_ORDER   = 4'd6,
    C_SIZE    = 4'd7,
    C_SKIP    = 4'd8
  } cause_e;

  // lowest VA bit indexed by a given level
  function automatic int lvl_lo_bit(input int lvl);
    return PG_SHIFT + IDX_W * (lvl - 1);
  endfunction
endpackage

// File: rtl/pw_skip_chk.sv
module pw_skip_chk #(
  parameter int VA_W  = pw_pkg::VA_W,
  parameter int LVL_W = pw_pkg::LVL_W
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic [LVL_W-1:0] next_lvl_i,
  output logic             skip_bad_o
);
  int lo_bit, hi_bit;

  always_comb begin
    // skipped levels: next+1 .. cur-1
    lo_bit     = pw_pkg::lvl_lo_bit(int'(next_lvl_i) + 1);
    hi_bit     = pw_pkg::lvl_lo_bit(int'(cur_lvl_i));
    skip_bad_o = 1'b0;
    if (next_lvl_i != '0) begin
      for (int b = 0; b < VA_W; b++) begin
        if (b >= lo_bit && b < hi_bit && va_i[b]) skip_bad_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pw_step_eval.sv
module pw_step_eval
  import pw_pkg::*;
#(
  parameter int VA_W    = pw_pkg::VA_W,
  parameter int LVL_W   = pw_pkg::LVL_W,
  parameter int MAX_LVL = pw_pkg::MAX_LVL,
  parameter int ACC_W   = pw_pkg::ACC_W
) (
  input  logic             dte_valid_i,
  input  logic [LVL_W-1:0] root_lvl_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             present_i,
  input  logic [ACC_W-1:0] perm_i,
  input  logic [LVL_W-1:0] next_lvl_i,
  input  logic [LVL_W-1:0] pgsz_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [VA_W-1:0]  va_i,
  output action_e          action_o,
  output cause_e           cause_o,
  output logic             flt_present_o,
  output logic             flt_perm_o
);
  localparam logic [LVL_W-1:0] MAX_CODE = LVL_W'(MAX_LVL);

  logic skip_bad;

  pw_skip_chk #(.VA_W(VA_W), .LVL_W(LVL_W)) u_skip (
    .va_i      (va_i),
    .cur_lvl_i (cur_lvl_i),
    .next_lvl_i(next_lvl_i),
    .skip_bad_o(skip_bad)
  );

  // fixed priority: first failing check wins
  always_comb begin
    cause_o = C_NONE;
    if (!dte_valid_i)                                   cause_o = C_XLATE;
    else if (root_lvl_i == '0 || root_lvl_i > MAX_CODE) cause_o = C_ROOT;
    else if ((acc_i & ~perm_i) != '0)                   cause_o = C_PERM;
    else if (!present_i)                                cause_o = C_NOTPRES;
    else if (next_lvl_i > MAX_CODE)                     cause_o = C_NXT;
    else if (next_lvl_i != '0 && next_lvl_i >= cur_lvl_i) cause_o = C_ORDER;
    else if (next_lvl_i == '0 && pgsz_i >= cur_lvl_i)   cause_o = C_SIZE;
    else if (skip_bad)                                  cause_o = C_SKIP;
  end

  always_comb begin
    if (cause_o != C_NONE)      action_o = ACT_FAULT;
    else if (next_lvl_i == '0)  action_o = ACT_DONE;
    else                        action_o = ACT_DESCEND;
    flt_present_o = (cause_o != C_NONE) && (cause_o != C_XLATE) && (cause_o != C_NOTPRES);
    flt_perm_o    = (cause_o == C_PERM);
  end
endmodule

// File: rtl/pw_walk_check.sv
module pw_walk_check
  import pw_pkg::*;
#(
  parameter int VA_W    = pw_pkg::VA_W,
  parameter int LVL_W   = pw_pkg::LVL_W,
  parameter int MAX_LVL = pw_pkg::MAX_LVL,
  parameter int ID_W    = pw_pkg::ID_W,
  parameter int OP_W    = pw_pkg::OP_W,
  parameter int ACC_W   = pw_pkg::ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [ID_W-1:0]  dev_id_i,
  input  logic             dte_valid_i,
  input  logic [LVL_W-1:0] dte_root_lvl_i,
  input  logic [ID_W-1:0]  dte_dom_id_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             pte_present_i,
  input  logic [ACC_W-1:0] pte_perm_i,
  input  logic [LVL_W-1:0] pte_next_lvl_i,
  input  logic [LVL_W-1:0] pte_pgsz_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [VA_W-1:0]  va_i,
  output logic             rsp_valid_o,
  output logic [1:0]       action_o,
  output logic [LVL_W-1:0] next_lvl_o,
  output logic [3:0]       cause_o,
  output logic             flt_present_o,
  output logic             flt_perm_o,
  output logic [ID_W-1:0]  flt_dev_id_o,
  output logic [ID_W-1:0]  flt_dom_id_o,
  output logic [VA_W-1:0]  flt_va_o,
  output logic [OP_W-1:0]  flt_op_o
);
  action_e act_d;
  cause_e  cause_d;
  logic    pres_d, perm_d;

  pw_step_eval #(
    .VA_W(VA_W), .LVL_W(LVL_W), .MAX_LVL(MAX_LVL), .ACC_W(ACC_W)
  ) u_eval (
    .dte_valid_i  (dte_valid_i),
    .root_lvl_i   (dte_root_lvl_i),
    .cur_lvl_i    (cur_lvl_i),
    .present_i    (pte_present_i),
    .perm_i       (pte_perm_i),
    .next_lvl_i   (pte_next_lvl_i),
    .pgsz_i       (pte_pgsz_i),
    .acc_i        (acc_i),
    .va_i         (va_i),
    .action_o     (act_d),
    .cause_o      (cause_d),
    .flt_present_o(pres_d),
    .flt_perm_o   (perm_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      action_o      <= '0;
      next_lvl_o    <= '0;
      cause_o       <= '0;
      flt_present_o <= 1'b0;
      flt_perm_o    <= 1'b0;
      flt_dev_id_o  <= '0;
      flt_dom_id_o  <= '0;
      flt_va_o      <= '0;
      flt_op_o      <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        action_o      <= act_d;
        next_lvl_o    <= (act_d == ACT_DESCEND) ? pte_next_lvl_i : '0;
        cause_o       <= cause_d;
        flt_present_o <= pres_d;
        flt_perm_o    <= perm_d;
        flt_dev_id_o  <= dev_id_i;
        flt_dom_id_o  <= dte_dom_id_i;
        flt_va_o      <= va_i;
        flt_op_o      <= op_i;
      end
    end
  end

  // R3
  xlate_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(!dte_valid_i)) |-> (action_o == ACT_FAULT && !flt_present_o));

  // R5
  perm_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_perm_o |-> (flt_present_o && action_o == ACT_FAULT));

  // R12
  descend_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && action_o == ACT_DESCEND) |->
      (next_lvl_o != '0 && next_lvl_o < $past(cur_lvl_i)));

  // R11
  quiet_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && action_o != ACT_FAULT) |->
      (!flt_present_o && !flt_perm_o && cause_o == '0));

  // R2
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !$past(req_i)) |-> 1'b0);
endmodule

// File: tb/pw_walk_check_bench.sv
module pw_walk_check_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        req_i, dte_valid_i, pte_present_i;
  logic [15:0] dev_id_i, dte_dom_id_i;
  logic [2:0]  dte_root_lvl_i, cur_lvl_i, pte_next_lvl_i, pte_pgsz_i;
  logic [1:0]  pte_perm_i, acc_i, op_i;
  logic [63:0] va_i;
  logic        rsp_valid_o, flt_present_o, flt_perm_o;
  logic [1:0]  action_o, flt_op_o;
  logic [2:0]  next_lvl_o;
  logic [3:0]  cause_o;
  logic [15:0] flt_dev_id_o, flt_dom_id_o;
  logic [63:0] flt_va_o;

  pw_walk_check u_pw_walk_check (.*);

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [2:0]  root;
    logic [2:0]  cur;
    logic        vld;
    logic        pres;
    logic [1:0]  perm;
    logic [2:0]  nxt;
    logic [2:0]  pgsz;
    logic [1:0]  acc;
    logic [63:0] va;
    logic [1:0]  act;
    logic [3:0]  cause;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{3'd4, 3'd4, 1'b1, 1'b1, 2'd3, 3'd3, 3'd0, 2'd1, 64'h0,          2'd0, 4'd0}, // R12 descend
    '{3'd4, 3'd1, 1'b1, 1'b1, 2'd3, 3'd0, 3'd0, 2'd1, 64'h0,          2'd1, 4'd0}, // R12 leaf
    '{3'd4, 3'd3, 1'b1, 1'b1, 2'd3, 3'd0, 3'd2, 2'd3, 64'h0,          2'd1, 4'd0}, // R9 legal large page
    '{3'd4, 3'd4, 1'b0, 1'b1, 2'd3, 3'd3, 3'd0, 2'd1, 64'h0,          2'd2, 4'd1}, // R3
    '{3'd0, 3'd4, 1'b1, 1'b1, 2'd3, 3'd3, 3'd0, 2'd1, 64'h0,          2'd2, 4'd2}, // R4 low
    '{3'd7, 3'd4, 1'b1, 1'b1, 2'd3, 3'd3, 3'd0, 2'd1, 64'h0,          2'd2, 4'd2}, // R4 high
    '{3'd4, 3'd4, 1'b1, 1'b1, 2'd1, 3'd3, 3'd0, 2'd2, 64'h0,          2'd2, 4'd3}, // R5
    '{3'd4, 3'd4, 1'b1, 1'b0, 2'd3, 3'd3, 3'd0, 2'd1, 64'h0,          2'd2, 4'd4}, // R6
    '{3'd4, 3'd4, 1'b1, 1'b1, 2'd3, 3'd7, 3'd0, 2'd1, 64'h0,          2'd2, 4'd5}, // R7
    '{3'd4, 3'd4, 1'b1, 1'b1, 2'd3, 3'd4, 3'd0, 2'd1, 64'h0,          2'd2, 4'd6}, // R8 equal
    '{3'd4, 3'd3, 1'b1, 1'b1, 2'd3, 3'd0, 3'd3, 2'd1, 64'h0,          2'd2, 4'd7}, // R9 size
    '{3'd4, 3'd4, 1'b1, 1'b1, 2'd3, 3'd1, 3'd0, 2'd1, 64'h200000,     2'd2, 4'd8}, // R10 bit 21
    '{3'd4, 3'd4, 1'b1, 1'b1, 2'd3, 3'd1, 3'd0, 2'd1, 64'h4000000000, 2'd2, 4'd8}, // R10 bit 38
    '{3'd4, 3'd4, 1'b1, 1'b1, 2'd3, 3'd1, 3'd0, 2'd1, 64'h80001FFFFF, 2'd0, 4'd0}, // R10 bits 39,20..0 ok
    '{3'd4, 3'd4, 1'b0, 1'b0, 2'd3, 3'd7, 3'd0, 2'd1, 64'h0,          2'd2, 4'd1}, // R11 vld first
    '{3'd4, 3'd4, 1'b1, 1'b0, 2'd1, 3'd3, 3'd0, 2'd2, 64'h0,          2'd2, 4'd3}, // R11 perm over present
    '{3'd4, 3'd4, 1'b1, 1'b0, 2'd3, 3'd7, 3'd0, 2'd1, 64'h0,          2'd2, 4'd4}, // R11 present over next
    '{3'd0, 3'd4, 1'b1, 1'b1, 2'd0, 3'd4, 3'd0, 2'd3, 64'h0,          2'd2, 4'd2}  // R11 root over perm
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    dte_root_lvl_i = v.root; cur_lvl_i = v.cur; dte_valid_i = v.vld;
    pte_present_i = v.pres; pte_perm_i = v.perm; pte_next_lvl_i = v.nxt;
    pte_pgsz_i = v.pgsz; acc_i = v.acc; va_i = v.va;
  endtask

  task automatic step();
    req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req_i = 0; dev_id_i = 0; dte_dom_id_i = 0; op_i = 0;
    drive(VEC[0]);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid_o, 0);
    chk("R1 action", action_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 flags", {flt_present_o, flt_perm_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", rsp_valid_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic exp_pres, exp_perm;
      drive(VEC[i]);
      step();
      exp_pres = (VEC[i].act == 2'd2) && (VEC[i].cause != 4'd1) && (VEC[i].cause != 4'd4);
      exp_perm = (VEC[i].cause == 4'd3);
      chk($sformatf("R11 vec%0d action", i), action_o, VEC[i].act);
      chk($sformatf("R11 vec%0d cause", i), cause_o, VEC[i].cause);
      chk($sformatf("R3-R10 vec%0d present flag", i), flt_present_o, exp_pres);
      chk($sformatf("R5 vec%0d perm flag", i), flt_perm_o, exp_perm);
      chk($sformatf("R12 vec%0d next level", i), next_lvl_o,
          (VEC[i].act == 2'd0) ? VEC[i].nxt : 3'd0);
    end

    // R2 record fields and single-cycle strobe
    drive(VEC[7]);
    dev_id_i = 16'hBEEF; dte_dom_id_i = 16'h1234; op_i = 2'd2; va_i = 64'hDEAD_0000_1000;
    step();
    chk("R2 rsp_valid", rsp_valid_o, 1);
    chk("R2 dev id", flt_dev_id_o, 16'hBEEF);
    chk("R2 dom id", flt_dom_id_o, 16'h1234);
    chk("R2 va", flt_va_o, 64'hDEAD_0000_1000);
    chk("R2 op", flt_op_o, 2);
    chk("R6 cause", cause_o, 4);
    @(negedge clk_i);
    chk("R2 one cycle", rsp_valid_o, 0);

    // R8 next level above current, R12 descend by several levels with clean bits
    drive(VEC[0]); cur_lvl_i = 3'd2; pte_next_lvl_i = 3'd3;
    step();
    chk("R8 above current", cause_o, 6);
    drive(VEC[0]); cur_lvl_i = 3'd6; dte_root_lvl_i = 3'd6; pte_next_lvl_i = 3'd2;
    va_i = 64'h1F_FFFF;
    step();
    chk("R12 skip descend action", action_o, 0);
    chk("R12 skip descend level", next_lvl_o, 2);
    va_i = 64'h4000_0000; // bit 30: level 3, skipped
    step();
    chk("R10 level-6 skip", cause_o, 8);

    // R1 reset clears a pending response
    drive(VEC[3]);
    step();
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 async clear valid", rsp_valid_o, 0);
    chk("R1 async clear cause", cause_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule